// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins an A bus and a B bus through a set of independent lanes. With the default parameters it has two 8-bit lanes, which can be used separately or driven with identical controls as one 16-bit path. Each lane has two storage registers, one for each direction. The A-to-B register captures A-side data, and the B-to-A register captures B-side data. Each register has its own capture strobe.

On each path a source select chooses what the driven bus receives. It can receive the live data from the opposite bus, or the word held in that path's register. An active-low enable and a direction control decide which bus, if either, is driven. The design works in a single clock domain. A capture strobe acts on the first rising clock edge at which it is seen high after being low. Bidirectional pins are split into separate input, output and per-bit output-enable vectors for each bus. Capture never depends on the enable or the direction, so a lane can store data while it is isolated, and it can store the data on a bus it is itself driving.

Top module: `xcvr_dual`

## Requirements
- R1: A synchronous active-low reset clears both storage registers of every lane to zero. After reset, replaying stored data returns all-zero words.
- R2: The first clock edge at which `cap_ab[h]` is high, after it was low on the previous edge, loads lane h's A-to-B register with that lane's slice of `a_in`. The slice is `a_in[h*8 +: 8]` with default parameters.
- R3: The first clock edge at which `cap_ba[h]` is high, after it was low on the previous edge, loads lane h's B-to-A register with that lane's slice of `b_in`.
- R4: Holding a capture strobe high for more than one edge captures only once. A register keeps its contents on every edge without a capture.
- R5: When `oe_n[h]` is 1, every bit of lane h in `a_oe` and `b_oe` is 0. This is isolation.
- R6: When `oe_n[h]` is 0, `dir[h]`=1 sets every bit of lane h in `b_oe` and clears `a_oe`. `dir[h]`=0 does the reverse. The two buses are never enabled together within a lane.
- R7: `sel_ab[h]`=0 sends the live A slice to lane h of `b_out`. `sel_ab[h]`=1 sends the A-to-B register instead. The output changes in the same cycle as the select, with no clock edge between.
- R8: `sel_ba[h]`=0 sends the live B slice to lane h of `a_out`. `sel_ba[h]`=1 sends the B-to-A register instead.
- R9: Capture works regardless of `oe_n` and `dir`. This includes while the lane is isolated, and while the captured bus is the one being driven.
- R10: The controls of one lane affect only that lane's bits of the outputs and registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| oe_n | input | 2 | Per-lane active-low output enable |
| dir | input | 2 | Per-lane direction, 1 drives B, 0 drives A |
| cap_ab | input | 2 | Per-lane capture strobe for the A-to-B register |
| cap_ba | input | 2 | Per-lane capture strobe for the B-to-A register |
| sel_ab | input | 2 | Per-lane B-output source, 1 selects stored data |
| sel_ba | input | 2 | Per-lane A-output source, 1 selects stored data |
| a_in | input | 16 | Value present on the A bus |
| a_out | output | 16 | Value to drive onto the A bus |
| a_oe | output | 16 | Per-bit enable for driving the A bus |
| b_in | input | 16 | Value present on the B bus |
| b_out | output | 16 | Value to drive onto the B bus |
| b_oe | output | 16 | Per-bit enable for driving the B bus |

## Verification
A storage register holding the wrong word stays hidden until that path's select is switched to stored data with the matching bus enabled. At that point the error shows on the output in the same cycle. The bench therefore reads back every capture through a replay, one clock edge after the strobe. A wrong edge detector shows up as a missed capture or a second capture while the strobe is held high, which a changed bus value exposes two edges later. A wrong enable or multiplexer decode is seen combinationally at once. This is covered by sweeping every control combination of each lane, with the other lane held in a different state.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  typedef struct packed {
    logic a_en;
    logic b_en;
  } drive_t;

  function automatic drive_t drive_of(input logic oe_n, input logic dir);
    drive_t d;
    d.b_en = ~oe_n & dir;
    d.a_en = ~oe_n & ~dir;
    return d;
  endfunction

endpackage

// File: rtl/xcvr_edge.sv
module xcvr_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl;
  end

  assign rise = lvl & ~prev_q;

  p_single_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/xcvr_store.sv
module xcvr_store #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end

  p_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(q));
  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> q == $past(d));
endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane
  import xcvr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         oe_n,
  input  logic         dir,
  input  logic         cap_ab,
  input  logic         cap_ba,
  input  logic         sel_ab,
  input  logic         sel_ba,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] a_out,
  output logic [W-1:0] a_oe,
  output logic [W-1:0] b_out,
  output logic [W-1:0] b_oe
);
  logic         rise_ab, rise_ba;
  logic [W-1:0] st_ab, st_ba;
  drive_t       drv;

  xcvr_edge u_edge_ab (.clk(clk), .rst_n(rst_n), .lvl(cap_ab), .rise(rise_ab));
  xcvr_edge u_edge_ba (.clk(clk), .rst_n(rst_n), .lvl(cap_ba), .rise(rise_ba));

  xcvr_store #(.W(W)) u_st_ab (.clk(clk), .rst_n(rst_n), .load(rise_ab), .d(a_in), .q(st_ab));
  xcvr_store #(.W(W)) u_st_ba (.clk(clk), .rst_n(rst_n), .load(rise_ba), .d(b_in), .q(st_ba));

  assign drv   = drive_of(oe_n, dir);
  assign b_out = sel_ab ? st_ab : a_in;
  assign a_out = sel_ba ? st_ba : b_in;
  assign b_oe  = {W{drv.b_en}};
  assign a_oe  = {W{drv.a_en}};

  p_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (st_ab == '0 && st_ba == '0));
  p_cap_ab_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rise_ab |=> st_ab == $past(a_in));
  p_cap_ba_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rise_ba |=> st_ba == $past(b_in));
  p_isolate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> (a_oe == '0 && b_oe == '0));
  p_one_bus_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !((|a_oe) && (|b_oe)));
endmodule

// File: rtl/xcvr_dual.sv
module xcvr_dual #(
  parameter int LANE_W = 8,
  parameter int LANES  = 2,
  localparam int W     = LANE_W * LANES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] oe_n,
  input  logic [LANES-1:0] dir,
  input  logic [LANES-1:0] cap_ab,
  input  logic [LANES-1:0] cap_ba,
  input  logic [LANES-1:0] sel_ab,
  input  logic [LANES-1:0] sel_ba,
  input  logic [W-1:0]     a_in,
  output logic [W-1:0]     a_out,
  output logic [W-1:0]     a_oe,
  input  logic [W-1:0]     b_in,
  output logic [W-1:0]     b_out,
  output logic [W-1:0]     b_oe
);
  for (genvar h = 0; h < LANES; h++) begin : g_lane
    xcvr_lane #(.W(LANE_W)) u_lane (
      .clk    (clk),
      .rst_n  (rst_n),
      .oe_n   (oe_n[h]),
      .dir    (dir[h]),
      .cap_ab (cap_ab[h]),
      .cap_ba (cap_ba[h]),
      .sel_ab (sel_ab[h]),
      .sel_ba (sel_ba[h]),
      .a_in   (a_in[h*LANE_W +: LANE_W]),
      .b_in   (b_in[h*LANE_W +: LANE_W]),
      .a_out  (a_out[h*LANE_W +: LANE_W]),
      .a_oe   (a_oe[h*LANE_W +: LANE_W]),
      .b_out  (b_out[h*LANE_W +: LANE_W]),
      .b_oe   (b_oe[h*LANE_W +: LANE_W])
    );
  end
endmodule

// File: tb/sim_xcvr_dual.sv
module sim_xcvr_dual;
  localparam int CLK_PERIOD = 10;
  localparam int LW = 8;
  localparam int NL = 2;
  localparam int W  = LW * NL;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NL-1:0] oe_n = '1, dir = '0, cap_ab = '0, cap_ba = '0, sel_ab = '0, sel_ba = '0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] a_out, a_oe, b_out, b_oe;

  int n_chk = 0;
  int n_bad = 0;
  logic [LW-1:0] m_ab [NL];
  logic [LW-1:0] m_ba [NL];

  always #(CLK_PERIOD/2) clk = ~clk;

  xcvr_dual u0 (.clk(clk), .rst_n(rst_n), .oe_n(oe_n), .dir(dir), .cap_ab(cap_ab),
    .cap_ba(cap_ba), .sel_ab(sel_ab), .sel_ba(sel_ba), .a_in(a_in), .a_out(a_out),
    .a_oe(a_oe), .b_in(b_in), .b_out(b_out), .b_oe(b_oe));

  task automatic check_all(input string tag);
    logic [W-1:0] ea_oe, eb_oe, ea, eb;
    for (int h = 0; h < NL; h++) begin
      logic en;
      en = (oe_n[h] == 1'b0);
      eb_oe[h*LW +: LW] = {LW{en && dir[h]}};
      ea_oe[h*LW +: LW] = {LW{en && !dir[h]}};
      eb[h*LW +: LW] = sel_ab[h] ? m_ab[h] : a_in[h*LW +: LW];
      ea[h*LW +: LW] = sel_ba[h] ? m_ba[h] : b_in[h*LW +: LW];
    end
    n_chk++;
    if (a_oe !== ea_oe || b_oe !== eb_oe ||
        ((b_out ^ eb) & eb_oe) != '0 || ((a_out ^ ea) & ea_oe) != '0) begin
      n_bad++;
      $display("FAIL %s: a_oe=%h b_oe=%h a_out=%h b_out=%h expected a_oe=%h b_oe=%h a_out=%h b_out=%h",
               tag, a_oe, b_oe, a_out, b_out, ea_oe, eb_oe, ea, eb);
    end
  endtask

  // read back one register of lane h through the normal replay path
  task automatic replay(input int h, input bit ab_path, input string tag);
    @(negedge clk);
    oe_n[h] = 1'b0; dir[h] = ab_path; sel_ab[h] = 1'b1; sel_ba[h] = 1'b1;
    #1 check_all(tag);
  endtask

  task automatic cap_a(input int h, input logic [LW-1:0] v);
    @(negedge clk);
    a_in[h*LW +: LW] = v; cap_ab[h] = 1'b1;
    @(negedge clk);
    cap_ab[h] = 1'b0; m_ab[h] = v;
  endtask

  task automatic cap_b(input int h, input logic [LW-1:0] v);
    @(negedge clk);
    b_in[h*LW +: LW] = v; cap_ba[h] = 1'b1;
    @(negedge clk);
    cap_ba[h] = 1'b0; m_ba[h] = v;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int h = 0; h < NL; h++) begin m_ab[h] = '0; m_ba[h] = '0; end
    a_in = 16'h5AA5; b_in = 16'h3CC3;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: cleared registers replayed on both buses, and isolation right after reset (R5)
    #1 check_all("R5 reset isolation");
    for (int h = 0; h < NL; h++) begin
      replay(h, 1'b1, "R1 cleared A-to-B register");
      replay(h, 1'b0, "R1 cleared B-to-A register");
    end

    // R2, R3, R9: capture while isolated, then replay
    @(negedge clk); oe_n = '1;
    cap_a(0, 8'h12); cap_a(1, 8'hE7);
    cap_b(0, 8'h9C); cap_b(1, 8'h41);
    a_in = 16'h0000; b_in = 16'hFFFF;
    for (int h = 0; h < NL; h++) begin
      replay(h, 1'b1, "R2 R9 A capture while isolated");
      replay(h, 1'b0, "R3 R9 B capture while isolated");
    end

    // R9: capture a bus while that same lane drives it
    @(negedge clk); oe_n[0] = 1'b0; dir[0] = 1'b0; sel_ba[0] = 1'b0;
    cap_a(0, 8'h6B);
    @(negedge clk); dir[0] = 1'b1; sel_ab[0] = 1'b0;
    cap_b(0, 8'hD2);
    replay(0, 1'b1, "R9 A capture while A driven");
    replay(0, 1'b0, "R9 B capture while B driven");

    // R4: strobe held high captures once
    @(negedge clk); a_in[LW +: LW] = 8'h33; cap_ab[1] = 1'b1;
    @(negedge clk); a_in[LW +: LW] = 8'hCC;
    @(negedge clk); @(negedge clk);
    m_ab[1] = 8'h33;
    replay(1, 1'b1, "R4 held strobe no recapture");
    @(negedge clk); cap_ab[1] = 1'b0;
    @(negedge clk); @(negedge clk);
    replay(1, 1'b1, "R4 register kept without strobe");

    // R5..R8, R10: sweep every control combination per lane, other lane fixed differently
    for (int p = 0; p < 3; p++) begin
      for (int h = 0; h < NL; h++) begin
        for (int c = 0; c < 16; c++) begin
          @(negedge clk);
          a_in = 16'h1357 * (p + 1) + 16'h0F0F * c;
          b_in = 16'hFFFF ^ (16'h2468 * (p + 3) + 16'h0101 * c);
          oe_n[h] = c[0]; dir[h] = c[1]; sel_ab[h] = c[2]; sel_ba[h] = c[3];
          oe_n[1-h] = 1'b0; dir[1-h] = ~c[1]; sel_ab[1-h] = ~c[2]; sel_ba[1-h] = ~c[3];
          #1 check_all("R5 R6 R7 R8 R10 control sweep");
        end
      end
    end

    // R7, R8: same-cycle switch between live and stored
    @(negedge clk); oe_n = '0; dir = 2'b01; sel_ab = '0; sel_ba = '0;
    #1 check_all("R7 R8 live");
    sel_ab = '1; sel_ba = '1;
    #1 check_all("R7 R8 stored same cycle");

    // R10: capture in one lane leaves the other lane's register intact
    cap_a(0, 8'hA0);
    replay(1, 1'b1, "R10 other lane register untouched");
    replay(0, 1'b1, "R2 R10 lane 0 new capture");

    // R1: reset mid-run clears again
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    for (int h = 0; h < NL; h++) begin m_ab[h] = '0; m_ba[h] = '0; end
    for (int h = 0; h < NL; h++) begin
      replay(h, 1'b1, "R1 second reset A-to-B");
      replay(h, 1'b0, "R1 second reset B-to-A");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule